// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects up to 32 interrupt lines and reduces them to a single request and a vector number for the core. Each line has its own sensing mode: rising-edge or level-high. Every input passes through a two-flop synchroniser before any detection. Edge events latch into a pending bit that software clears by writing ones. Level sources simply mirror the synchronised input. An enable mask gates which pending sources raise the request. Among the active sources, the lowest index wins and is reported as its index plus a fixed vector offset.

A second mask selects sources that may wake the core while it is idle. Setting a bit in the wake mask also turns that source on in the enable mask.

A read-only configuration word reports an implementation version and a 3-bit code for the number of inputs. The code maps to 6, 2, 10, 16, 24 or 32 inputs for values 0 to 5. Codes 6 and 7 are unsupported and leave no live sources.

Software reaches all of this through a small register port. The port takes one write per cycle and returns read data combinationally.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, the pending, enable, trigger and wake registers read zero, and irq_o and wake_o are low.
- R2: A source whose trigger bit is 1 is edge-sensed. Its pending bit is set on the third clock edge after a rising input, not earlier, and it stays set after the input falls.
- R3: Writing to address 0 clears the pending bit of every edge-sensed source whose data bit is 1. Bits written as 0 leave pending state unchanged.
- R4: A source whose trigger bit is 0 is level-sensed. Its pending bit equals the input level with a three-edge latency, and a clearing write has no lasting effect while the input stays high.
- R5: irq_o is high exactly when some source is both pending and enabled in the enable register (address 1, 1 = enabled). A pending source that is masked does not raise irq_o.
- R6: While irq_o is high, vec_o equals the lowest active source index plus VEC_OFS, and it is 0 otherwise. Address 4 reads irq_o in bit 31 and vec_o in bits 7:0, with all other bits zero.
- R7: A write to the wake register (address 3) also sets every written 1 bit in the enable register. Clearing a wake bit leaves the enable register unchanged.
- R8: wake_o is high exactly when idle_i is high and some source is both pending and set in the wake register.
- R9: Address 5 reads the input-count code in bits 2:0 and the nonzero version in bits 15:8, with all other bits zero.
- R10: Bits at or above the configured input count read zero in every register, ignore writes, and ignore their inputs.
- R11: The enable (1), trigger (2) and wake (3) registers read back the last value written to them, limited to the live bits. Unmapped addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_src_i | input | 32 | Raw interrupt lines, asynchronous to clk_i |
| idle_i | input | 1 | Core is idle; qualifies wake_o |
| reg_addr_i | input | 3 | Register address |
| reg_we_i | input | 1 | Write strobe, one write per cycle |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake request |
| vec_o | output | VEC_W | Winning vector number, 0 when idle |

## Verification
The assertions assume that reg_addr_i and reg_we_i are driven to known values in every cycle out of reset. They also assume that the configuration leaves VEC_OFS + 31 within VEC_W bits, so the vector-to-index mapping cannot wrap.

The bench stimulus stays inside these assumptions in two ways. It changes every input at the falling edge only. It also draws addresses from the six mapped registers, so each write lands on a defined register.

Random source toggling is kept sparse, so that edges, levels and clearing writes interleave in many orders.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  localparam int unsigned SRC_MAX = 32;

  typedef enum logic [2:0] {
    A_PEND = 3'd0,
    A_ENA  = 3'd1,
    A_TRIG = 3'd2,
    A_WAKE = 3'd3,
    A_VEC  = 3'd4,
    A_CFG  = 3'd5
  } reg_addr_e;

  function automatic int unsigned src_count(logic [2:0] code);
    case (code)
      3'd0:    return 6;
      3'd1:    return 2;
      3'd2:    return 10;
      3'd3:    return 16;
      3'd4:    return 24;
      3'd5:    return 32;
      default: return 0;
    endcase
  endfunction

  function automatic logic [SRC_MAX-1:0] live_mask(logic [2:0] code);
    int unsigned n;
    n = src_count(code);
    if (n >= SRC_MAX) return '1;
    return (SRC_MAX'(1) << n) - SRC_MAX'(1);
  endfunction

endpackage

// File: rtl/irq_vec_sync.sv
module irq_vec_sync #(
  parameter int unsigned             W    = 32,
  parameter logic [W-1:0]            LIVE = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= src_i & LIVE;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q & LIVE;
  assign rise_o = s2_q & ~prev_q & LIVE;
endmodule

// File: rtl/irq_vec_regs.sv
module irq_vec_regs
  import irq_vec_pkg::*;
#(
  parameter int unsigned  W    = 32,
  parameter logic [W-1:0] LIVE = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [2:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] trig_o,
  output logic [W-1:0] wake_o
);
  logic [W-1:0] wd;
  assign wd = wdata_i & LIVE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= '0;
      trig_o <= '0;
      wake_o <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_ENA:  en_o   <= wd;
        A_TRIG: trig_o <= wd;
        A_WAKE: begin
          wake_o <= wd;
          en_o   <= en_o | wd; // wake forces enable, never clears it
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_vec_pend.sv
module irq_vec_pend #(
  parameter int unsigned  W    = 32,
  parameter logic [W-1:0] LIVE = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] trig_i,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] pend_d;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      // edge: set wins over a same-cycle clear
      pend_d[i] = trig_i[i] ? ((pend_o[i] & ~clr_i[i]) | rise_i[i]) : lvl_i[i];
    end
    pend_d &= LIVE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= pend_d;
  end
endmodule

// File: rtl/irq_vec_prio.sv
module irq_vec_prio #(
  parameter int unsigned W       = 32,
  parameter int unsigned VEC_OFS = 9,
  parameter int unsigned VEC_W   = 8
) (
  input  logic [W-1:0]     req_i,
  output logic             hit_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1;
  logic [IDX_W-1:0] idx;

  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) idx = IDX_W'(i);
    end
    hit_o = |req_i;
    vec_o = hit_o ? (VEC_W'(VEC_OFS) + VEC_W'(idx)) : '0;
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter logic [2:0]  CNT_CODE = 3'd5,
  parameter logic [7:0]  VERSION  = 8'h01,
  parameter int unsigned VEC_OFS  = 9,
  parameter int unsigned VEC_W    = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [31:0]        irq_src_i,
  input  logic               idle_i,
  input  logic [2:0]         reg_addr_i,
  input  logic               reg_we_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic               irq_o,
  output logic               wake_o,
  output logic [VEC_W-1:0]   vec_o
);
  localparam int unsigned       W    = SRC_MAX;
  localparam int unsigned       NSRC = src_count(CNT_CODE);
  localparam logic [W-1:0]      LIVE = live_mask(CNT_CODE);

  logic [W-1:0] lvl, rise, clr;
  logic [W-1:0] pend_q, en_q, trig_q, wake_q;

  irq_vec_sync #(.W(W), .LIVE(LIVE)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (irq_src_i),
    .lvl_o  (lvl),
    .rise_o (rise)
  );

  irq_vec_regs #(.W(W), .LIVE(LIVE)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .en_o    (en_q),
    .trig_o  (trig_q),
    .wake_o  (wake_q)
  );

  assign clr = (reg_we_i && reg_addr_i == A_PEND) ? reg_wdata_i : '0;

  irq_vec_pend #(.W(W), .LIVE(LIVE)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig_q),
    .lvl_i  (lvl),
    .rise_i (rise),
    .clr_i  (clr),
    .pend_o (pend_q)
  );

  irq_vec_prio #(.W(W), .VEC_OFS(VEC_OFS), .VEC_W(VEC_W)) u_prio (
    .req_i (pend_q & en_q),
    .hit_o (irq_o),
    .vec_o (vec_o)
  );

  assign wake_o = idle_i & |(pend_q & wake_q);

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_PEND: reg_rdata_o = pend_q;
      A_ENA:  reg_rdata_o = en_q;
      A_TRIG: reg_rdata_o = trig_q;
      A_WAKE: reg_rdata_o = wake_q;
      A_VEC: begin
        reg_rdata_o[31]        = irq_o;
        reg_rdata_o[VEC_W-1:0] = vec_o;
      end
      A_CFG: begin
        reg_rdata_o[2:0]  = CNT_CODE;
        reg_rdata_o[15:8] = VERSION;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  logic unused_nsrc;
  assign unused_nsrc = (NSRC > W);
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk
  import irq_vec_pkg::*;
#(
  parameter logic [2:0]  CNT_CODE = 3'd5,
  parameter int unsigned VEC_OFS  = 9,
  parameter int unsigned VEC_W    = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             idle_i,
  input logic             reg_we_i,
  input logic [2:0]       reg_addr_i,
  input logic [31:0]      reg_wdata_i,
  input logic             irq_o,
  input logic             wake_o,
  input logic [VEC_W-1:0] vec_o,
  input logic [31:0]      pend_q,
  input logic [31:0]      en_q,
  input logic [31:0]      trig_q,
  input logic [31:0]      wake_q
);
  localparam logic [31:0] LIVE = live_mask(CNT_CODE);
  localparam int unsigned NSRC = src_count(CNT_CODE);

  logic [31:0]      req;
  logic [VEC_W-1:0] idx;
  logic [31:0]      below;
  logic             edge_quiet;

  assign req        = pend_q & en_q;
  assign idx        = vec_o - VEC_W'(VEC_OFS);
  assign below      = (32'd1 << idx) - 32'd1;
  assign edge_quiet = !(reg_we_i && (reg_addr_i == A_PEND || reg_addr_i == A_TRIG));

  AST_IDLE_GATES_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |-> !wake_o); // R8

  AST_VEC_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (vec_o >= VEC_W'(VEC_OFS)) && (32'(idx) < NSRC)); // R6

  AST_VEC_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (req[idx[4:0]] && ((req & below) == '0))); // R6

  AST_DEAD_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q | en_q | trig_q | wake_q) & ~LIVE) == '0); // R10

  AST_EDGE_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_quiet |=> (($past(pend_q & trig_q) & ~pend_q) == '0)); // R2

  AST_WAKE_SETS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_WAKE) |=>
      ((en_q & $past(reg_wdata_i & LIVE)) == $past(reg_wdata_i & LIVE))); // R7
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(
  .CNT_CODE (CNT_CODE),
  .VEC_OFS  (VEC_OFS),
  .VEC_W    (VEC_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .idle_i      (idle_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .irq_o       (irq_o),
  .wake_o      (wake_o),
  .vec_o       (vec_o),
  .pend_q      (pend_q),
  .en_q        (en_q),
  .trig_q      (trig_q),
  .wake_q      (wake_q)
);

// File: tb/irq_vec_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb_top;
  logic clk_i = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic        rst_ni;
  logic [31:0] src;
  logic        idle;
  logic [2:0]  addr;
  logic        we;
  logic [31:0] wd;
  logic [31:0] rdata, rdata_b;
  logic        irq, wake, irq_b, wake_b;
  logic [7:0]  vec, vec_b;

  irq_vec_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_src_i(src), .idle_i(idle),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wd), .reg_rdata_o(rdata),
    .irq_o(irq), .wake_o(wake), .vec_o(vec)
  );

  irq_vec_ctrl #(.CNT_CODE(3'd1), .VERSION(8'h3C), .VEC_OFS(16)) dut_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_src_i(src), .idle_i(idle),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wd), .reg_rdata_o(rdata_b),
    .irq_o(irq_b), .wake_o(wake_b), .vec_o(vec_b)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // requirement-level model of dut_i (32 live sources, offset 9)
  logic [31:0] m_s1, m_s2, m_prev, m_pend, m_en, m_trig, m_wake;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_pend = '0;
      m_en = '0; m_trig = '0; m_wake = '0;
    end else begin
      logic [31:0] clr, np, ne, nt, nw;
      clr = (we && addr == 3'd0) ? wd : '0;
      for (int i = 0; i < 32; i++)
        np[i] = m_trig[i] ? ((m_pend[i] & ~clr[i]) | (m_s2[i] & ~m_prev[i])) : m_s2[i];
      ne = m_en; nt = m_trig; nw = m_wake;
      if (we && addr == 3'd1) ne = wd;
      if (we && addr == 3'd2) nt = wd;
      if (we && addr == 3'd3) begin nw = wd; ne = m_en | wd; end
      m_pend = np; m_en = ne; m_trig = nt; m_wake = nw;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = src;
    end
  end

  function automatic logic [31:0] f_vec(logic [31:0] req);
    logic [31:0] v;
    v = 0;
    for (int i = 31; i >= 0; i--) if (req[i]) v = 32'(i + 9);
    return v;
  endfunction

  function automatic logic [31:0] f_rd(logic [2:0] a);
    logic [31:0] req;
    req = m_pend & m_en;
    case (a)
      3'd0: return m_pend;
      3'd1: return m_en;
      3'd2: return m_trig;
      3'd3: return m_wake;
      3'd4: return {(req != 0), 23'd0, f_vec(req)[7:0]};
      3'd5: return 32'h0000_0105;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; we = 1'b1; wd = d;
    @(negedge clk_i);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    addr = a;
    #1;
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_ni = 1'b0; src = '0; idle = 1'b0; addr = '0; we = 1'b0; wd = '0;
    step(2);
    rst_ni = 1'b1;
    step(1);

    for (int a = 0; a < 4; a++) begin
      rd(3'(a));
      chk("R1 register reset", rdata, 32'h0);
    end
    chk("R1 irq_o reset", {31'd0, irq}, 32'd0);
    chk("R1 wake_o reset", {31'd0, wake}, 32'd0);
    rd(3'd5);
    chk("R9 config word", rdata, 32'h0000_0105);
    chk("R9 config word small", rdata_b, 32'h0000_3C01);
    rd(3'd7);
    chk("R11 unmapped read", rdata, 32'h0);

    wr(3'd2, 32'h0000_0010);
    wr(3'd1, 32'h0000_0210);
    rd(3'd2);
    chk("R11 trigger readback", rdata, 32'h0000_0010);

    src[4] = 1'b1;
    step(2); rd(3'd0);
    chk("R2 edge latency not yet", rdata, 32'h0);
    step(1); rd(3'd0);
    chk("R2 edge pending set", rdata, 32'h0000_0010);
    src[4] = 1'b0;
    step(4); rd(3'd0);
    chk("R2 edge pending held", rdata, 32'h0000_0010);
    chk("R6 vector", {24'd0, vec}, 32'd13);
    rd(3'd4);
    chk("R6 vector register", rdata, 32'h8000_000D);

    src[9] = 1'b1;
    step(3); rd(3'd0);
    chk("R4 level pending", rdata, 32'h0000_0210);
    chk("R6 lowest wins", {24'd0, vec}, 32'd13);
    wr(3'd0, 32'h0000_0210);
    rd(3'd0);
    chk("R3 clear edge keep level", rdata, 32'h0000_0200);
    chk("R6 next vector", {24'd0, vec}, 32'd18);
    src[9] = 1'b0;
    step(3); rd(3'd0);
    chk("R4 level drops", rdata, 32'h0);
    chk("R5 irq idle", {31'd0, irq}, 32'd0);

    src[5] = 1'b1;
    step(3); rd(3'd0);
    chk("R5 masked pending", rdata, 32'h0000_0020);
    chk("R5 masked no irq", {31'd0, irq}, 32'd0);

    wr(3'd3, 32'h0010_0000);
    rd(3'd1);
    chk("R7 wake sets enable", rdata, 32'h0010_0210);
    rd(3'd3);
    chk("R11 wake readback", rdata, 32'h0010_0000);
    src[20] = 1'b1; idle = 1'b0;
    step(3); #1;
    chk("R8 no wake when busy", {31'd0, wake}, 32'd0);
    idle = 1'b1; #1;
    chk("R8 wake when idle", {31'd0, wake}, 32'd1);
    wr(3'd3, 32'h0);
    rd(3'd1);
    chk("R7 wake clear keeps enable", rdata, 32'h0010_0210);
    chk("R8 wake off", {31'd0, wake}, 32'd0);

    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1);
    chk("R10 enable dead bits", rdata_b, 32'h0000_0003);
    wr(3'd2, 32'hFFFF_FFFF);
    src = 32'hFFFF_FFFF;
    step(3); rd(3'd0);
    chk("R10 pending dead bits", rdata_b, 32'h0000_0003);
    chk("R6 vector offset small", {24'd0, vec_b}, 32'd16);
    chk("R6 vector all active", {24'd0, vec}, 32'd9);
    src = '0;
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0);
    chk("R3 clear all edges", rdata, 32'h0);

    for (int c = 0; c < 800; c++) begin
      chk("R5 irq random", {31'd0, irq}, {31'd0, ((m_pend & m_en) != 0)});
      chk("R6 vector random", {24'd0, vec}, f_vec(m_pend & m_en));
      chk("R8 wake random", {31'd0, wake}, {31'd0, idle & ((m_pend & m_wake) != 0)});
      chk("R11 readback random", rdata, f_rd(addr));
      src  = src ^ ($urandom & $urandom & $urandom);
      idle = 1'($urandom);
      addr = 3'($urandom % 6);
      we   = ($urandom % 4) == 0;
      wd   = $urandom;
      step(1);
    end
    we = 1'b0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule